// File: doc/BRIEF.md
# Parallel Port Extended Control Unit

This block holds the extended control register of a parallel port that supports the enhanced capabilities protocol, along with the mode decoder and a 16-entry byte FIFO that this register governs. A host register interface reads and writes the control register, the data register, the FIFO port and two configuration registers. The three-bit mode field sets four things: whether the FIFO is held cleared, where a data-register read comes from, which registers are visible, and whether FIFO contents are offered for transmission.

The cable handshake engines sit outside the block. The block meets them through a strobe interface. In the forward direction it holds `tx_req` high with the head byte and a command tag, and the engine pops that byte by pulsing `tx_ack`. In the reverse direction the engine pushes a received byte by pulsing `rx_valid`. The block also drives the output enable of the data lines, a DMA request, and an interrupt. The interrupt is raised by a synchronised falling edge on the active-low fault input.

Host offsets: 0x000 data register, 0x400 FIFO port (configuration A in configuration mode), 0x401 configuration B, 0x402 control register. Control register layout: bits 7:5 mode, bit 4 fault-interrupt disable (active high), bit 3 DMA enable, bit 2 interrupt pending (write 1 to acknowledge), bit 1 full, bit 0 empty.

Top module: `pp_ext_ctrl`

## Requirements
- R1: Bits 7:5 of the control register at 0x402 are a read/write mode field, encoded as 000 standard, 001 bidirectional, 010 FIFO, 011 ECP, 100 EPP, 101 reserved, 110 test and 111 configuration. Bits 4 and 3 read back as written.
- R2: While the mode is 000 the FIFO is cleared within one clock and reports empty (bit 0 = 1), so no earlier content survives a return to another mode.
- R3: In mode 001, `dir_rev` = 1 drives `pin_oe` low and a read of 0x000 returns `pin_data_in`. In all other cases a read of 0x000 returns the last value written to the data register.
- R4: In mode 010 with `dir_rev` = 0, FIFO bytes are offered in write order on `tx_byte` with `tx_is_cmd` = 0, and each `tx_ack` pops one byte. While `dir_rev` = 1, `tx_req` stays low.
- R5: In mode 011 with `dir_rev` = 0, writes to 0x400 (data, tag 0) and writes to 0x000 (command, tag 1) enter one FIFO in write order. With `dir_rev` = 1, `pin_oe` is low, each `rx_valid` pushes `rx_byte`, and reads of 0x400 pop in arrival order.
- R6: In mode 110 the host writes and reads the FIFO at 0x400, and `tx_req` never rises.
- R7: Configuration registers A (0x400) and B (0x401) can be written and read only in mode 111. Outside that mode, writes to 0x401 have no effect and reads of 0x401 return 0.
- R8: `dma_req` is 0 whenever bit 3 is 0. With bit 3 set, forward transmit modes request while the FIFO is not full.
- R9: With bit 4 = 0, a falling edge on `fault_n` sets the pending bit (bit 2, and `irq`) on the third clock after the edge. With bit 4 = 1, falling edges set nothing, and rising edges never set it.
- R10: Writing the control register with bit 2 = 1 clears the pending interrupt. A new edge arriving in the same cycle takes precedence.
- R11: Bit 1 (full) and bit 0 (empty) follow the occupancy of the 16-byte FIFO. A write when full and a pop when empty are ignored, and a read of an empty FIFO returns 0.
- R12: After reset the control register reads 0x11 (mode 000, fault interrupt disabled, DMA off, nothing pending, empty), and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops the FIFO at 0x400 where allowed) |
| host_addr | input | 11 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational on the offset |
| dir_rev | input | 1 | Port direction: 0 forward, 1 reverse |
| pin_data_in | input | 8 | Sampled data-line values |
| pin_data_out | output | 8 | Data register value toward the lines |
| pin_oe | output | 1 | Data line output enable |
| tx_req | output | 1 | A byte is offered to the handshake engine |
| tx_byte | output | 8 | Offered byte |
| tx_is_cmd | output | 1 | Offered byte is a command/address byte |
| tx_ack | input | 1 | Engine consumed the offered byte |
| rx_valid | input | 1 | Engine produced a reverse byte |
| rx_byte | input | 8 | Reverse byte |
| fault_n | input | 1 | Asynchronous active-low fault line |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the FIFO to its limit and then writes one more byte. A design with a loose full check would overwrite the oldest byte or wrap the count, and the scrambled readback would show it. It leaves bytes in the FIFO across a switch to standard mode, where a missing flush shows up as stale data. It interleaves data and command writes in ECP mode, where a separate command path or a lost tag would reorder bytes or mislabel them. It also drives both edges of the fault line with the enable set and with it cleared. A detector that reacts to the level or to the rising edge, or that ignores the disable bit, raises an interrupt where none is due.

// File: rtl/pp_ext_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and host offsets of the parallel port
// extended control unit. Assumes an 11-bit host offset space.
package pp_ext_pkg;

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_FIFO  = 3'b010,
        MODE_ECP   = 3'b011,
        MODE_EPP   = 3'b100,
        MODE_RSVD  = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } pp_mode_e;

    localparam int         HOST_AW  = 11;
    localparam logic [10:0] OFF_DATA = 11'h000;
    localparam logic [10:0] OFF_FIFO = 11'h400;
    localparam logic [10:0] OFF_CFGB = 11'h401;
    localparam logic [10:0] OFF_CTRL = 11'h402;

endpackage

// File: rtl/pp_byte_fifo.sv
`timescale 1ns/1ps
// Module: pp_byte_fifo
// Synchronous FIFO with a clear input that takes priority over push and pop.
// A push while full and a pop while empty are dropped. Assumes DEPTH is a
// power of two, so the pointers wrap on their own.
module pp_byte_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write: accepted pushes only.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pp_fault_edge.sv
`timescale 1ns/1ps
// Module: pp_fault_edge
// Brings the asynchronous active-low fault line through a synchroniser of
// SYNC_STAGES flops, then flags a falling edge for one cycle.
// Assumes SYNC_STAGES >= 2. The idle level after reset is high.
module pp_fault_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain and edge-detect history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = prev_q && !sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pp_ext_ctrl.sv
`timescale 1ns/1ps
// Module: pp_ext_ctrl
// Extended control unit of a parallel port. It holds the control register,
// data register, two configuration registers and a tagged byte FIFO. The mode
// field gates FIFO clearing, readback source, register visibility and
// transmit offering. The cable handshake engines are external and connect
// through tx_req/tx_ack and rx_valid. Assumes single-cycle host strobes.
module pp_ext_ctrl
    import pp_ext_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               dir_rev,
    input  logic [7:0]         pin_data_in,
    output logic [7:0]         pin_data_out,
    output logic               pin_oe,
    output logic               tx_req,
    output logic [7:0]         tx_byte,
    output logic               tx_is_cmd,
    input  logic               tx_ack,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               fault_n,
    output logic               dma_req,
    output logic               irq
);
    localparam int EW = 9;

    pp_mode_e    ecr_mode;
    logic        fault_dis, dma_en, irq_pend;
    logic [7:0]  data_reg, cfg_a, cfg_b;
    logic        sel_data, sel_fifo, sel_cfgb, sel_ctrl;
    logic        tx_mode, ecp_rev, fault_fall;
    logic        push_host_data, push_host_cmd, push_rx, host_pop;
    logic        fifo_push, fifo_pop, fifo_clr, fifo_full, fifo_empty;
    logic [EW-1:0] fifo_din, fifo_dout;

    assign sel_data = (host_addr == OFF_DATA);
    assign sel_fifo = (host_addr == OFF_FIFO);
    assign sel_cfgb = (host_addr == OFF_CFGB);
    assign sel_ctrl = (host_addr == OFF_CTRL);

    assign tx_mode = ((ecr_mode == MODE_FIFO) || (ecr_mode == MODE_ECP)) && !dir_rev;
    assign ecp_rev = (ecr_mode == MODE_ECP) && dir_rev;

    // FIFO source selection: host data port, host command port or receive side.
    always_comb begin
        push_host_data = host_wr && sel_fifo &&
                         ((ecr_mode == MODE_FIFO) || (ecr_mode == MODE_TEST) ||
                          ((ecr_mode == MODE_ECP) && !dir_rev));
        push_host_cmd  = host_wr && sel_data && (ecr_mode == MODE_ECP) && !dir_rev;
        push_rx        = rx_valid && ecp_rev;
        host_pop       = host_rd && sel_fifo && ((ecr_mode == MODE_TEST) || ecp_rev);
        fifo_push      = push_host_data || push_host_cmd || push_rx;
        if (push_rx)            fifo_din = {1'b0, rx_byte};
        else if (push_host_cmd) fifo_din = {1'b1, host_wdata};
        else                    fifo_din = {1'b0, host_wdata};
    end

    assign fifo_pop = host_pop || (tx_req && tx_ack);
    assign fifo_clr = (ecr_mode == MODE_STD);

    pp_byte_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (fifo_din),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pp_fault_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_n (fault_n),
        .fall    (fault_fall)
    );

    // Control register fields written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecr_mode  <= MODE_STD;
            fault_dis <= 1'b1;
            dma_en    <= 1'b0;
        end else if (host_wr && sel_ctrl) begin
            ecr_mode  <= pp_mode_e'(host_wdata[7:5]);
            fault_dis <= host_wdata[4];
            dma_en    <= host_wdata[3];
        end
    end

    // Pending interrupt: a captured edge wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 irq_pend <= 1'b0;
        else if (fault_fall && !fault_dis)          irq_pend <= 1'b1;
        else if (host_wr && sel_ctrl && host_wdata[2]) irq_pend <= 1'b0;
    end

    // Data register and mode-gated configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_reg <= '0;
            cfg_a    <= '0;
            cfg_b    <= '0;
        end else if (host_wr) begin
            if (sel_data && (ecr_mode != MODE_ECP))       data_reg <= host_wdata;
            if (sel_fifo && (ecr_mode == MODE_CFG))       cfg_a    <= host_wdata;
            if (sel_cfgb && (ecr_mode == MODE_CFG))       cfg_b    <= host_wdata;
        end
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (sel_data)
            host_rdata = (ecr_mode == MODE_BIDIR && dir_rev) ? pin_data_in : data_reg;
        else if (sel_fifo)
            host_rdata = (ecr_mode == MODE_CFG) ? cfg_a :
                         (fifo_empty ? 8'h00 : fifo_dout[7:0]);
        else if (sel_cfgb)
            host_rdata = (ecr_mode == MODE_CFG) ? cfg_b : 8'h00;
        else if (sel_ctrl)
            host_rdata = {ecr_mode, fault_dis, dma_en, irq_pend, fifo_full, fifo_empty};
    end

    assign pin_data_out = data_reg;
    assign pin_oe       = ((ecr_mode == MODE_BIDIR) || (ecr_mode == MODE_ECP)) ? !dir_rev : 1'b1;
    assign tx_req       = tx_mode && !fifo_empty;
    assign tx_byte      = fifo_dout[7:0];
    assign tx_is_cmd    = fifo_dout[8];
    assign dma_req      = dma_en && ((tx_mode && !fifo_full) || (ecp_rev && !fifo_empty));
    assign irq          = irq_pend;
endmodule

// File: rtl/pp_ext_ctrl_chk.sv
`timescale 1ns/1ps
// Module: pp_ext_ctrl_chk
// Property checker for pp_ext_ctrl. It observes the mode, the FIFO flags and
// the outputs. It is attached to every pp_ext_ctrl instance by the bind below.
module pp_ext_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       fifo_push,
    input logic       fifo_pop,
    input logic       fault_dis,
    input logic       dma_en,
    input logic       dir_rev,
    input logic       tx_req,
    input logic       dma_req,
    input logic       irq
);
    a_r2_std_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000) |=> fifo_empty);

    a_r4_rev_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rev |-> !tx_req);

    a_r6_test_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b110) |-> !tx_req);

    a_r8_dma_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    a_r9_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_dis) && !$past(irq)) |-> !irq);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && fifo_push && !fifo_pop && mode != 3'b000) |=> fifo_full);
endmodule

bind pp_ext_ctrl pp_ext_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (ecr_mode),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fault_dis  (fault_dis),
    .dma_en     (dma_en),
    .dir_rev    (dir_rev),
    .tx_req     (tx_req),
    .dma_req    (dma_req),
    .irq        (irq)
);

// File: tb/test_pp_ext_ctrl.sv
`timescale 1ns/1ps
// Bench for pp_ext_ctrl. The driver tasks queue the bytes expected on the
// transmit side, and a monitor pops and compares them as the design offers them.
module test_pp_ext_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dir_rev = 1'b0;
    logic [7:0]  pin_data_in = '0;
    logic [7:0]  pin_data_out;
    logic        pin_oe, tx_req, tx_is_cmd, dma_req, irq;
    logic [7:0]  tx_byte;
    logic        tx_ack = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        fault_n = 1'b1;

    int          n_chk = 0, n_bad = 0;
    bit          ack_on = 1'b0;
    logic [8:0]  exp_q[$];
    logic [7:0]  rv;

    always #4 clk = ~clk;

    pp_ext_ctrl i_pp_ext_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dir_rev(dir_rev), .pin_data_in(pin_data_in), .pin_data_out(pin_data_out),
        .pin_oe(pin_oe), .tx_req(tx_req), .tx_byte(tx_byte), .tx_is_cmd(tx_is_cmd),
        .tx_ack(tx_ack), .rx_valid(rx_valid), .rx_byte(rx_byte), .fault_n(fault_n),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Driver: record the expected transmit item, then write it.
    task automatic send(input logic [10:0] a, input logic [7:0] d, input logic is_cmd);
        exp_q.push_back({is_cmd, d});
        host_write(a, d);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 80 && exp_q.size() > 0; i++) @(negedge clk);
        check(req, 9'(exp_q.size()), 9'd0);
    endtask

    // Monitor: accept offered bytes and compare them with the queue head.
    always @(negedge clk) begin
        tx_ack = 1'b0;
        if (rst_n && tx_req && ack_on) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected transmit", {tx_is_cmd, tx_byte}, 9'h1ff);
            end else begin
                check("R4/R5 transmit order", {tx_is_cmd, tx_byte}, exp_q.pop_front());
            end
            tx_ack = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset values
        host_read(11'h402, rv); check("R12 ctrl reset", 9'(rv), 9'h011);
        host_read(11'h000, rv); check("R12 data reset", 9'(rv), 9'h000);

        // R1 mode field readback (test mode, fault disabled)
        host_write(11'h402, 8'hD0);
        host_read(11'h402, rv); check("R1 ctrl readback", 9'(rv), 9'h0D1);

        // R11 fill to full, overflow ignored; R6 no transmit in test mode
        for (int i = 0; i < 16; i++) host_write(11'h400, 8'(i * 3 + 1));
        host_read(11'h402, rv); check("R11 full flag", 9'(rv), 9'h0D2);
        check("R6 no tx in test", 9'(tx_req), 9'd0);
        host_write(11'h400, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            host_read(11'h400, rv); check("R11/R6 fifo readback", 9'(rv), 9'(i * 3 + 1));
        end
        host_read(11'h400, rv); check("R11 empty read", 9'(rv), 9'h000);
        host_read(11'h402, rv); check("R11 empty flag", 9'(rv), 9'h0D1);

        // R2 standard mode flushes
        host_write(11'h400, 8'h5A);
        host_write(11'h400, 8'h5B);
        host_write(11'h402, 8'h10);
        host_read(11'h402, rv); check("R2 std empty", 9'(rv), 9'h011);
        host_write(11'h402, 8'hD0);
        host_read(11'h400, rv); check("R2 no stale byte", 9'(rv), 9'h000);

        // R4 FIFO mode: reverse blocks transmit, forward drains in order
        host_write(11'h402, 8'h50);
        dir_rev = 1'b1;
        send(11'h400, 8'h55, 1'b0);
        #1 check("R4 reverse no tx", 9'(tx_req), 9'd0);
        dir_rev = 1'b0;
        ack_on = 1'b1;
        send(11'h400, 8'h11, 1'b0);
        send(11'h400, 8'h22, 1'b0);
        send(11'h400, 8'h33, 1'b0);
        drain("R4 drained");

        // R8 DMA gating
        #1 check("R8 dma off", 9'(dma_req), 9'd0);
        host_write(11'h402, 8'h58);
        #1 check("R8 dma fwd", 9'(dma_req), 9'd1);
        host_write(11'h402, 8'hD8);
        #1 check("R8 dma test idle", 9'(dma_req), 9'd0);

        // R5 ECP forward: shared FIFO with tags
        host_write(11'h402, 8'h70);
        send(11'h400, 8'hA1, 1'b0);
        send(11'h000, 8'h5B, 1'b1);
        send(11'h400, 8'hA2, 1'b0);
        send(11'h000, 8'h5C, 1'b1);
        drain("R5 drained");

        // R5 ECP reverse: receive push, host pop
        ack_on = 1'b0;
        dir_rev = 1'b1;
        #1 check("R5 reverse oe", 9'(pin_oe), 9'd0);
        @(negedge clk); rx_byte = 8'h3C; rx_valid = 1'b1;
        @(negedge clk); rx_byte = 8'h3D;
        @(negedge clk); rx_valid = 1'b0;
        host_read(11'h400, rv); check("R5 rx first", 9'(rv), 9'h03C);
        host_read(11'h400, rv); check("R5 rx second", 9'(rv), 9'h03D);

        // R3 bidirectional readback source
        host_write(11'h402, 8'h10);
        dir_rev = 1'b0;
        host_write(11'h000, 8'h42);
        host_write(11'h402, 8'h30);
        dir_rev = 1'b1; pin_data_in = 8'h96;
        #1 check("R3 oe off", 9'(pin_oe), 9'd0);
        host_read(11'h000, rv); check("R3 pin readback", 9'(rv), 9'h096);
        dir_rev = 1'b0;
        host_write(11'h402, 8'h10);
        host_read(11'h000, rv); check("R3 reg readback", 9'(rv), 9'h042);
        check("R3 oe std", 9'(pin_oe), 9'd1);

        // R7 configuration visibility
        host_write(11'h401, 8'h77);
        host_write(11'h402, 8'hF0);
        host_read(11'h401, rv); check("R7 blocked write", 9'(rv), 9'h000);
        host_write(11'h400, 8'h12);
        host_write(11'h401, 8'h34);
        host_read(11'h400, rv); check("R7 cfg A", 9'(rv), 9'h012);
        host_read(11'h401, rv); check("R7 cfg B", 9'(rv), 9'h034);
        host_write(11'h402, 8'h10);
        host_read(11'h401, rv); check("R7 hidden", 9'(rv), 9'h000);

        // R9 and R10 fault interrupt
        host_write(11'h402, 8'h00);
        @(negedge clk); fault_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 irq set", 9'(irq), 9'd1);
        host_read(11'h402, rv); check("R9 pending bit", 9'(rv), 9'h005);
        host_write(11'h402, 8'h04);
        #1 check("R10 cleared", 9'(irq), 9'd0);
        @(negedge clk); fault_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 rising ignored", 9'(irq), 9'd0);
        host_write(11'h402, 8'h10);
        @(negedge clk); fault_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 disabled", 9'(irq), 9'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule